// File: doc/BRIEF.md
# Dual-Processor Shared Memory Mailbox with Doorbell Interrupts

This block holds a word-addressed memory that two requesters on one processing channel share: a computational side (CP) and an input/output side (IO). Each side has its own request/grant port. On that port it issues a read, a write or an atomic test-and-set. A round-robin arbiter serves one access per clock. When both sides ask in the same cycle, the side that was not served last goes first.

The top four words of the memory have side effects. When CP stores to its doorbell word, an interrupt is raised toward IO. When IO stores to its doorbell word, an interrupt is raised toward CP. The stored word stays readable, so it serves as a short command code. A longer message can be placed anywhere in ordinary memory before the doorbell store. Each interrupt stays high until the receiving side stores to its own acknowledge word. Test-and-set returns the old word and writes a nonzero lock value in the same arbitrated cycle, so software semaphores can guard block transfers.

Top module: `mbox_shmem`

## Requirements
- R1: A word written by either side is returned by a later read of that address from either side.
- R2: In any cycle at most one grant is high. A grant goes only to a side that is requesting. Whenever at least one side requests outside reset, one side is granted.
- R3: When both sides request in the same cycle, the side not granted most recently wins. The first contested cycle after reset goes to CP.
- R4: Op codes are 2'b00 read, 2'b01 write, 2'b10 test-and-set, and 2'b11, which acts as a read. For a read or a test-and-set, that side's rvalid is high in the cycle after its grant, with the addressed word on its rdata. A write raises no rvalid.
- R5: Test-and-set returns the word held before the access and leaves the lock value TAS_VAL (default 1) stored, as one access.
- R6: A write or test-and-set by CP to address 2^AW-2 (62 by default) stores the word and raises io_irq from the next cycle.
- R7: A write or test-and-set by IO to address 2^AW-1 (63 by default) stores the word and raises cp_irq from the next cycle.
- R8: io_irq stays high until IO stores to address 2^AW-4 (60). cp_irq stays high until CP stores to address 2^AW-3 (61). Each clears in the next cycle.
- R9: A store by the wrong side to a doorbell or acknowledge address only stores data and leaves both interrupts unchanged.
- R10: While rst is high, no grant is given. After reset, both interrupts and both rvalid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cp_req | input | 1 | CP access request |
| cp_op | input | 2 | CP op code |
| cp_addr | input | AW | CP word address |
| cp_wdata | input | DW | CP write data |
| cp_gnt | output | 1 | CP access accepted this cycle |
| cp_rvalid | output | 1 | CP read data valid |
| cp_rdata | output | DW | CP read data |
| cp_irq | output | 1 | Doorbell interrupt toward CP |
| io_req | input | 1 | IO access request |
| io_op | input | 2 | IO op code |
| io_addr | input | AW | IO word address |
| io_wdata | input | DW | IO write data |
| io_gnt | output | 1 | IO access accepted this cycle |
| io_rvalid | output | 1 | IO read data valid |
| io_rdata | output | DW | IO read data |
| io_irq | output | 1 | Doorbell interrupt toward IO |

## Verification
The properties assume that each requester holds its request, op, address and data steady until it is granted. The alternation and doorbell checks rely on this. The bench changes inputs only on falling edges and drops a request only after its grant has been seen. In the contested sequences, the losing side keeps its request up until it wins. Every address the bench reads has been written first, because the memory array itself is not cleared by reset.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [1:0] {
        OP_RD  = 2'b00,
        OP_WR  = 2'b01,
        OP_TAS = 2'b10,
        OP_RDX = 2'b11
    } op_e;

    typedef enum logic {
        SIDE_CP = 1'b0,
        SIDE_IO = 1'b1
    } side_e;

    localparam int NUM_SIDES = 2;

    function automatic logic op_stores(op_e op);
        return (op == OP_WR) || (op == OP_TAS);
    endfunction

    function automatic logic op_returns(op_e op);
        return (op != OP_WR);
    endfunction

endpackage

// File: rtl/mbox_arb.sv
module mbox_arb
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_cp,
    input  logic req_io,
    output logic gnt_cp,
    output logic gnt_io
);
    side_e prio_q;

    always_comb begin
        gnt_cp = !rst && req_cp && (!req_io || prio_q == SIDE_CP);
        gnt_io = !rst && req_io && (!req_cp || prio_q == SIDE_IO);
    end

    always_ff @(posedge clk) begin
        if (rst)         prio_q <= SIDE_CP;
        else if (gnt_cp) prio_q <= SIDE_IO;
        else if (gnt_io) prio_q <= SIDE_CP;
    end
endmodule

// File: rtl/mbox_store.sv
module mbox_store #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          en,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            rdata <= mem[addr];
            if (wr) mem[addr] <= wdata;
        end
    end
endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell (
    input  logic clk,
    input  logic rst,
    input  logic ring,
    input  logic ack,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)       irq <= 1'b0;
        else if (ring) irq <= 1'b1;
        else if (ack)  irq <= 1'b0;
    end
endmodule

// File: rtl/mbox_shmem.sv
module mbox_shmem
    import mbox_pkg::*;
#(
    parameter int AW      = 6,
    parameter int DW      = 16,
    parameter int TAS_VAL = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cp_req,
    input  logic [1:0]    cp_op,
    input  logic [AW-1:0] cp_addr,
    input  logic [DW-1:0] cp_wdata,
    output logic          cp_gnt,
    output logic          cp_rvalid,
    output logic [DW-1:0] cp_rdata,
    output logic          cp_irq,
    input  logic          io_req,
    input  logic [1:0]    io_op,
    input  logic [AW-1:0] io_addr,
    input  logic [DW-1:0] io_wdata,
    output logic          io_gnt,
    output logic          io_rvalid,
    output logic [DW-1:0] io_rdata,
    output logic          io_irq
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] DB_TO_IO  = AW'(DEPTH - 2);
    localparam logic [AW-1:0] DB_TO_CP  = AW'(DEPTH - 1);
    localparam logic [AW-1:0] ACK_AT_IO = AW'(DEPTH - 4);
    localparam logic [AW-1:0] ACK_AT_CP = AW'(DEPTH - 3);
    localparam logic [DW-1:0] LOCK_WORD = DW'(TAS_VAL);

    typedef struct packed {
        logic          vld;
        side_e         side;
        op_e           op;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } acc_t;

    acc_t          acc;
    logic          acc_store;
    logic [DW-1:0] store_word;
    logic [DW-1:0] rdata_q;
    logic          irq_v [NUM_SIDES];

    mbox_arb u_arb (
        .clk    (clk),
        .rst    (rst),
        .req_cp (cp_req),
        .req_io (io_req),
        .gnt_cp (cp_gnt),
        .gnt_io (io_gnt)
    );

    always_comb begin
        acc.vld = cp_gnt || io_gnt;
        if (io_gnt) begin
            acc.side  = SIDE_IO;
            acc.op    = op_e'(io_op);
            acc.addr  = io_addr;
            acc.wdata = io_wdata;
        end else begin
            acc.side  = SIDE_CP;
            acc.op    = op_e'(cp_op);
            acc.addr  = cp_addr;
            acc.wdata = cp_wdata;
        end
        acc_store  = acc.vld && op_stores(acc.op);
        store_word = (acc.op == OP_TAS) ? LOCK_WORD : acc.wdata;
    end

    mbox_store #(.AW(AW), .DW(DW)) u_store (
        .clk   (clk),
        .en    (acc.vld),
        .wr    (acc_store),
        .addr  (acc.addr),
        .wdata (store_word),
        .rdata (rdata_q)
    );

    // Direction d: the sender is side d, the receiver is the other side.
    for (genvar d = 0; d < NUM_SIDES; d++) begin : g_bell
        localparam logic [AW-1:0] RING_ADDR = (d == 0) ? DB_TO_IO : DB_TO_CP;
        localparam logic [AW-1:0] ACK_ADDR  = (d == 0) ? ACK_AT_IO : ACK_AT_CP;
        logic ring, ack;
        assign ring = acc_store && (acc.side == side_e'(d))
                      && (acc.addr == RING_ADDR);
        assign ack  = acc_store && (acc.side != side_e'(d))
                      && (acc.addr == ACK_ADDR);
        mbox_doorbell u_bell (
            .clk  (clk),
            .rst  (rst),
            .ring (ring),
            .ack  (ack),
            .irq  (irq_v[d])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cp_rvalid <= 1'b0;
            io_rvalid <= 1'b0;
        end else begin
            cp_rvalid <= cp_gnt && op_returns(acc.op);
            io_rvalid <= io_gnt && op_returns(acc.op);
        end
    end

    assign io_irq   = irq_v[0];
    assign cp_irq   = irq_v[1];
    assign cp_rdata = rdata_q;
    assign io_rdata = rdata_q;
endmodule

// File: rtl/mbox_shmem_chk.sv
module mbox_shmem_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          cp_req,
    input logic [1:0]    cp_op,
    input logic [AW-1:0] cp_addr,
    input logic          cp_gnt,
    input logic          cp_rvalid,
    input logic          cp_irq,
    input logic          io_req,
    input logic [1:0]    io_op,
    input logic [AW-1:0] io_addr,
    input logic          io_gnt,
    input logic          io_rvalid,
    input logic          io_irq
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] RING_IO = AW'(DEPTH - 2);
    localparam logic [AW-1:0] RING_CP = AW'(DEPTH - 1);
    localparam logic [AW-1:0] ACK_IO  = AW'(DEPTH - 4);
    localparam logic [AW-1:0] ACK_CP  = AW'(DEPTH - 3);

    logic cp_st, io_st;
    assign cp_st = cp_gnt && (cp_op == 2'b01 || cp_op == 2'b10);
    assign io_st = io_gnt && (io_op == 2'b01 || io_op == 2'b10);

    a_r2_one_grant: assert property (@(posedge clk) disable iff (rst)
        !(cp_gnt && io_gnt));
    a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (rst)
        (cp_gnt |-> cp_req) and (io_gnt |-> io_req));
    a_r2_no_idle: assert property (@(posedge clk) disable iff (rst)
        (cp_req || io_req) |-> (cp_gnt || io_gnt));
    a_r3_alternate: assert property (@(posedge clk) disable iff (rst)
        (cp_req && io_req && cp_gnt) ##1 (cp_req && io_req) |-> io_gnt);
    a_r4_cp_rvalid: assert property (@(posedge clk) disable iff (rst)
        cp_rvalid |-> $past(cp_gnt && cp_op != 2'b01));
    a_r4_io_rvalid: assert property (@(posedge clk) disable iff (rst)
        (io_gnt && io_op != 2'b01) |=> io_rvalid);
    a_r6_ring_io: assert property (@(posedge clk) disable iff (rst)
        (cp_st && cp_addr == RING_IO) |=> io_irq);
    a_r7_ring_cp: assert property (@(posedge clk) disable iff (rst)
        (io_st && io_addr == RING_CP) |=> cp_irq);
    a_r8_ack_io: assert property (@(posedge clk) disable iff (rst)
        (io_st && io_addr == ACK_IO) |=> !io_irq);
    a_r9_io_irq_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(io_irq) |-> $past(cp_st && cp_addr == RING_IO));
    a_r9_io_irq_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(io_irq) |-> $past(io_st && io_addr == ACK_IO));
    a_r9_cp_irq_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(cp_irq) |-> $past(cp_st && cp_addr == ACK_CP));
endmodule

bind mbox_shmem mbox_shmem_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst),
    .cp_req(cp_req), .cp_op(cp_op), .cp_addr(cp_addr), .cp_gnt(cp_gnt),
    .cp_rvalid(cp_rvalid), .cp_irq(cp_irq),
    .io_req(io_req), .io_op(io_op), .io_addr(io_addr), .io_gnt(io_gnt),
    .io_rvalid(io_rvalid), .io_irq(io_irq)
);

// File: tb/mbox_shmem_test.sv
module mbox_shmem_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cp_req = 0, io_req = 0;
    logic [1:0] cp_op = 0, io_op = 0;
    logic [5:0] cp_addr = 0, io_addr = 0;
    logic [15:0] cp_wdata = 0, io_wdata = 0;
    logic cp_gnt, cp_rvalid, cp_irq, io_gnt, io_rvalid, io_irq;
    logic [15:0] cp_rdata, io_rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_shmem uut (
        .clk(clk), .rst(rst),
        .cp_req(cp_req), .cp_op(cp_op), .cp_addr(cp_addr), .cp_wdata(cp_wdata),
        .cp_gnt(cp_gnt), .cp_rvalid(cp_rvalid), .cp_rdata(cp_rdata), .cp_irq(cp_irq),
        .io_req(io_req), .io_op(io_op), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_gnt(io_gnt), .io_rvalid(io_rvalid), .io_rdata(io_rdata), .io_irq(io_irq)
    );

    typedef struct packed {
        logic        side;
        logic [1:0]  op;
        logic [5:0]  addr;
        logic [15:0] wd;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 2'b01, 6'd3, 16'h1234, 16'h0000},
        '{1'b1, 2'b01, 6'd4, 16'hBEEF, 16'h0000},
        '{1'b1, 2'b00, 6'd3, 16'h0000, 16'h1234},
        '{1'b0, 2'b00, 6'd4, 16'h0000, 16'hBEEF},
        '{1'b0, 2'b01, 6'd3, 16'h00A5, 16'h0000},
        '{1'b1, 2'b11, 6'd3, 16'h0000, 16'h00A5},
        '{1'b0, 2'b01, 6'd7, 16'hFFFF, 16'h0000},
        '{1'b0, 2'b00, 6'd7, 16'h0000, 16'hFFFF}
    };

    task automatic check(input logic ok, input string tag,
                         input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic access(input logic side, input logic [1:0] op,
                          input logic [5:0] a, input logic [15:0] d,
                          output logic [15:0] rd, output logic rv);
        @(negedge clk);
        if (side) begin
            io_req = 1; io_op = op; io_addr = a; io_wdata = d;
        end else begin
            cp_req = 1; cp_op = op; cp_addr = a; cp_wdata = d;
        end
        #1;
        while (!(side ? io_gnt : cp_gnt)) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        cp_req = 0;
        io_req = 0;
        rd = side ? io_rdata : cp_rdata;
        rv = side ? io_rvalid : cp_rvalid;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R2 act=hang exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        logic rv;

        // R10: no grant while reset is high
        @(negedge clk);
        cp_req = 1;
        #1;
        check(cp_gnt == 0, "R10 grant in reset", 16'(cp_gnt), 16'h0);
        cp_req = 0;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!cp_irq && !io_irq, "R10 irq after reset", 16'({cp_irq, io_irq}), 16'h0);
        check(!cp_rvalid && !io_rvalid, "R10 rvalid after reset",
              16'({cp_rvalid, io_rvalid}), 16'h0);

        // R1 / R4: table walk
        for (int i = 0; i < NV; i++) begin
            access(TBL[i].side, TBL[i].op, TBL[i].addr, TBL[i].wd, rd, rv);
            if (TBL[i].op == 2'b01) begin
                check(rv == 0, "R4 write gives no rvalid", 16'(rv), 16'h0);
            end else begin
                check(rv == 1, "R4 read rvalid", 16'(rv), 16'h1);
                check(rd == TBL[i].exp, "R1 read data", rd, TBL[i].exp);
            end
        end

        // R5: test-and-set
        access(0, 2'b01, 6'd20, 16'h0000, rd, rv);
        access(0, 2'b10, 6'd20, 16'h0000, rd, rv);
        check(rv && rd == 16'h0000, "R5 first tas old word", rd, 16'h0000);
        access(1, 2'b10, 6'd20, 16'h0000, rd, rv);
        check(rv && rd == 16'h0001, "R5 second tas sees lock", rd, 16'h0001);
        access(0, 2'b01, 6'd20, 16'h0000, rd, rv);
        access(1, 2'b10, 6'd20, 16'h0000, rd, rv);
        check(rd == 16'h0000, "R5 tas after release", rd, 16'h0000);
        access(0, 2'b00, 6'd20, 16'h0000, rd, rv);
        check(rd == 16'h0001, "R5 lock value stored", rd, 16'h0001);

        // R6 / R8 / R9: doorbell toward IO
        access(0, 2'b01, 6'd10, 16'hC0DE, rd, rv);
        check(!io_irq, "R6 plain write no irq", 16'(io_irq), 16'h0);
        access(0, 2'b01, 6'd62, 16'h0042, rd, rv);
        check(io_irq && !cp_irq, "R6 cp doorbell raises io_irq",
              16'({io_irq, cp_irq}), 16'h2);
        access(1, 2'b00, 6'd62, 16'h0000, rd, rv);
        check(rd == 16'h0042, "R6 doorbell code readable", rd, 16'h0042);
        access(1, 2'b00, 6'd10, 16'h0000, rd, rv);
        check(rd == 16'hC0DE, "R6 message readable", rd, 16'hC0DE);
        check(io_irq, "R8 irq held across reads", 16'(io_irq), 16'h1);
        access(0, 2'b01, 6'd60, 16'h0000, rd, rv);
        check(io_irq, "R9 cp store to io ack ignored", 16'(io_irq), 16'h1);
        access(1, 2'b01, 6'd60, 16'h0000, rd, rv);
        check(!io_irq, "R8 io ack clears io_irq", 16'(io_irq), 16'h0);
        access(1, 2'b01, 6'd62, 16'h0011, rd, rv);
        check(!io_irq && !cp_irq, "R9 io store to cp doorbell ignored",
              16'({io_irq, cp_irq}), 16'h0);

        // R7 / R8: doorbell toward CP
        access(1, 2'b01, 6'd63, 16'h0007, rd, rv);
        check(cp_irq && !io_irq, "R7 io doorbell raises cp_irq",
              16'({cp_irq, io_irq}), 16'h2);
        access(0, 2'b00, 6'd63, 16'h0000, rd, rv);
        check(rd == 16'h0007, "R7 code readable", rd, 16'h0007);
        access(1, 2'b01, 6'd61, 16'h0000, rd, rv);
        check(cp_irq, "R9 io store to cp ack ignored", 16'(cp_irq), 16'h1);
        access(0, 2'b01, 6'd61, 16'h0000, rd, rv);
        check(!cp_irq, "R8 cp ack clears cp_irq", 16'(cp_irq), 16'h0);

        // R2 / R3: contention after a fresh reset
        do_reset();
        @(negedge clk);
        cp_req = 1; cp_op = 2'b01; cp_addr = 6'd5; cp_wdata = 16'hAAAA;
        io_req = 1; io_op = 2'b01; io_addr = 6'd5; io_wdata = 16'h5555;
        #1;
        check(cp_gnt && !io_gnt, "R3 first contest to cp",
              16'({cp_gnt, io_gnt}), 16'h2);
        @(negedge clk);
        cp_op = 2'b00;
        #1;
        check(io_gnt && !cp_gnt, "R3 second contest to io",
              16'({cp_gnt, io_gnt}), 16'h1);
        @(negedge clk);
        io_req = 0;
        #1;
        check(cp_gnt, "R2 lone requester granted", 16'(cp_gnt), 16'h1);
        @(negedge clk);
        cp_req = 0;
        check(cp_rvalid && cp_rdata == 16'h5555, "R3 grant order sets data",
              cp_rdata, 16'h5555);
        #1;
        check(!cp_gnt && !io_gnt, "R2 no grant without request",
              16'({cp_gnt, io_gnt}), 16'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule